// File: doc/BRIEF.md
# Parallel Host Command and Status Port

This block is the device side of a 16-bit microprocessor bus for a converter that has a programmable filter. The host drives a chip-select, a read/write line, a register-select line and a shared data bus. The block turns each chip-select assertion into one of four operations: write an instruction, write a data word, read the status register, or read the data register. An interrupt output tells the host when it has to act.

The block follows a fixed bring-up order. The interrupt rises once reset ends. The host then issues a load instruction and writes a fixed number of configuration words. These words go out on a simple storage write port. When the last word arrives, the interrupt rises again. The host then reads the status register to check for errors and issues a start instruction. From that point, data-register reads return the conversion word presented on an input stub.

The strobes are asynchronous to the system clock. They pass through a two-flop synchronizer, and an operation executes once, on the synchronized falling edge of chip-select. The whole port is active only while the mode-select input is held low.

Top module: `host_cmd_port`

## Requirements
- R1: The operation is chosen by the read/write line (1 = read, 0 = write) and the register-select line (1 = status or instruction, 0 = data). This gives four operations: instruction write, data write, status read and data read.
- R2: Each assertion of chip-select executes exactly one operation. The operation runs after the strobes pass a two-flop synchronizer. The read value is driven on the bus, with the output enable high, while a read select is held.
- R3: The interrupt is low while reset is asserted and goes high in the first cycles after reset is released.
- R4: An instruction write or a status read clears the interrupt.
- R5: Instruction code 0x0001 starts a configuration load. It clears the done, error and running bits and the ID selection. The next CFG_WORDS data writes go to the storage port in order, at addresses 0 to CFG_WORDS-1.
- R6: When the last configuration word is written, status bit 0 (done) is set and the interrupt is raised.
- R7: Status bit 1 (configuration error) is set in two cases: a data write arrives after CFG_WORDS words have already been loaded, or an instruction arrives before CFG_WORDS words have been written.
- R8: Instruction code 0x0002 sets status bit 3 (running) only when done is set and the error bit is clear. In every other case it is ignored.
- R9: Instruction code 0x0003 selects the device identification word. A data read returns the conversion input while running, otherwise the ID word if it has been selected, otherwise zero.
- R10: Any other instruction code sets status bit 2 (illegal instruction). A status read returns the value the status register held before the read, then clears bit 2. Status bits 15 to 4 read as zero.
- R11: While the mode-select input is high, no operation executes and the bus output enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| par_mode_n | input | 1 | Mode select; the port is active when this is low |
| cs_n | input | 1 | Chip-select, active low, asynchronous |
| rw | input | 1 | 1 = read, 0 = write |
| rs | input | 1 | 1 = status/instruction, 0 = data |
| bus_in | input | DW | Write data from the host |
| bus_out | output | DW | Read data to the host |
| bus_oe | output | 1 | Output enable for bus_out |
| irq | output | 1 | Interrupt request to the host |
| cfg_we | output | 1 | Configuration storage write strobe |
| cfg_addr | output | AW | Configuration storage address |
| cfg_wdata | output | DW | Configuration storage write data |
| conv_in | input | DW | Conversion result from the filter stub |

## Verification
The bench builds the block with CFG_WORDS = 3 and DEV_ID = 0xBEEF. A short word count lets one run cover an exact load, an overlong load, a load cut short by an instruction, and a clean load followed by a start. The distinct ID value makes it clear, on a data read, whether the block returned the ID word, the conversion stub or zero.

// File: rtl/host_cmd_port.sv
module host_cmd_port #(
  parameter int DW = 16,
  parameter int CFG_WORDS = 4,
  parameter logic [15:0] DEV_ID = 16'hC0DE,
  localparam int AW = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1,
  localparam int CW = $clog2(CFG_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          par_mode_n,
  input  logic          cs_n,
  input  logic          rw,
  input  logic          rs,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          irq,
  output logic          cfg_we,
  output logic [AW-1:0] cfg_addr,
  output logic [DW-1:0] cfg_wdata,
  input  logic [DW-1:0] conv_in
);
  localparam int SW = DW + 3;

  logic [SW-1:0] s1, s2;
  logic cs_d, por, loading, done, err, bad, run, id_sel;
  logic [CW-1:0] cnt;

  wire cs_s   = s2[SW-1];
  wire rw_s   = s2[SW-2];
  wire rs_s   = s2[SW-3];
  wire [DW-1:0] d_s = s2[DW-1:0];
  wire mode_en = ~par_mode_n;
  wire op     = mode_en & ~cs_s & cs_d;
  wire wr_ins = op & ~rw_s &  rs_s;
  wire wr_dat = op & ~rw_s & ~rs_s;
  wire rd_st  = op &  rw_s &  rs_s;
  wire rd_dat = op &  rw_s & ~rs_s;
  wire short_load = loading & (cnt < CW'(CFG_WORDS));
  wire err_after  = err | short_load;
  wire [DW-1:0] status = DW'({run, bad, err, done});

  assign bus_oe = mode_en & ~cs_s & rw_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= {3'b100, {DW{1'b0}}};
      s2 <= {3'b100, {DW{1'b0}}};
      cs_d <= 1'b1;
    end else begin
      s1 <= {cs_n, rw, rs, bus_in};
      s2 <= s1;
      cs_d <= cs_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por <= 1'b1; irq <= 1'b0; loading <= 1'b0; cnt <= '0;
      done <= 1'b0; err <= 1'b0; bad <= 1'b0; run <= 1'b0; id_sel <= 1'b0;
      bus_out <= '0; cfg_we <= 1'b0; cfg_addr <= '0; cfg_wdata <= '0;
    end else begin
      cfg_we <= 1'b0;
      por <= 1'b0;
      if (por) irq <= 1'b1;
      if (wr_ins) begin
        irq <= 1'b0;
        loading <= 1'b0;
        case (d_s[15:0])
          16'h0001: begin
            loading <= 1'b1; cnt <= '0; done <= 1'b0;
            err <= 1'b0; run <= 1'b0; id_sel <= 1'b0;
          end
          16'h0002: begin
            err <= err_after;
            if (done && !err_after) run <= 1'b1;
          end
          16'h0003: begin
            err <= err_after;
            id_sel <= 1'b1;
          end
          default: begin
            err <= err_after;
            bad <= 1'b1;
          end
        endcase
      end
      if (wr_dat && loading) begin
        if (short_load) begin
          cfg_we <= 1'b1;
          cfg_addr <= AW'(cnt);
          cfg_wdata <= d_s;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(CFG_WORDS - 1)) begin
            done <= 1'b1;
            irq <= 1'b1;
          end
        end else begin
          err <= 1'b1;
        end
      end
      if (rd_st) begin
        bus_out <= status;
        irq <= 1'b0;
        bad <= 1'b0;
      end
      if (rd_dat)
        bus_out <= run ? conv_in : (id_sel ? DW'(DEV_ID) : '0);
    end
  end

  // R5
  cfg_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (cfg_addr < AW'(CFG_WORDS)));
  // R8
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (done && !err));
  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(por) || (done && cfg_we)));
  // R11
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(par_mode_n) |-> !cfg_we);
  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(CFG_WORDS));
endmodule

// File: tb/sim_host_cmd_port.sv
module sim_host_cmd_port;
  localparam int DW = 16;
  localparam int NW = 3;
  localparam int AW = 2;
  localparam logic [15:0] ID = 16'hBEEF;
  localparam logic [15:0] CONV = 16'h5A5A;

  logic clk = 1'b0, rst_n = 1'b0, par_mode_n = 1'b0, cs_n = 1'b1, rw = 1'b0, rs = 1'b0;
  logic [DW-1:0] bus_in = '0, bus_out, cfg_wdata;
  logic bus_oe, irq, cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [DW-1:0] store [NW];
  int checks = 0, fails = 0, wcount = 0;

  always #2 clk = ~clk;

  host_cmd_port #(.DW(DW), .CFG_WORDS(NW), .DEV_ID(ID)) u0 (
    .clk(clk), .rst_n(rst_n), .par_mode_n(par_mode_n), .cs_n(cs_n), .rw(rw), .rs(rs),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .irq(irq),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .conv_in(CONV));

  always @(posedge clk) if (cfg_we) begin store[cfg_addr] <= cfg_wdata; wcount <= wcount + 1; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [DW-1:0] rd_val;
  logic oe_seen;
  task automatic bus_op(input logic r, input logic s, input logic [DW-1:0] d);
    @(negedge clk);
    rw = r; rs = s; bus_in = d; cs_n = 1'b0;
    repeat (5) @(negedge clk);
    rd_val = bus_out; oe_seen = bus_oe;
    cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // {rw, rs, check_read, data, expected_read, expected_irq}
  localparam int NV = 30;
  localparam logic [35:0] VEC [NV] = '{
    {1'b1,1'b1,1'b1,16'h0000,16'h0000,1'b0}, // R4 status read clears irq, R10 upper bits zero
    {1'b1,1'b0,1'b1,16'h0000,16'h0000,1'b0}, // R9 data read before ID select
    {1'b0,1'b1,1'b0,16'h0003,16'h0000,1'b0}, // R9 select ID
    {1'b1,1'b0,1'b1,16'h0000,16'hBEEF,1'b0}, // R9 ID returned
    {1'b0,1'b1,1'b0,16'h0002,16'h0000,1'b0}, // R8 start before load
    {1'b1,1'b1,1'b1,16'h0000,16'h0000,1'b0}, // R8 not running
    {1'b0,1'b1,1'b0,16'h0001,16'h0000,1'b0}, // R5 load
    {1'b0,1'b0,1'b0,16'h1111,16'h0000,1'b0}, // R5
    {1'b0,1'b0,1'b0,16'h2222,16'h0000,1'b0}, // R5
    {1'b0,1'b0,1'b0,16'h3333,16'h0000,1'b1}, // R6 completion irq
    {1'b1,1'b1,1'b1,16'h0000,16'h0001,1'b0}, // R6 done bit, R4 clear
    {1'b0,1'b0,1'b0,16'h4444,16'h0000,1'b0}, // R7 extra word
    {1'b1,1'b1,1'b1,16'h0000,16'h0003,1'b0}, // R7 error bit
    {1'b0,1'b1,1'b0,16'h0002,16'h0000,1'b0}, // R8 start with error
    {1'b1,1'b1,1'b1,16'h0000,16'h0003,1'b0}, // R8 ignored
    {1'b0,1'b1,1'b0,16'h0001,16'h0000,1'b0}, // R5 reload
    {1'b1,1'b1,1'b1,16'h0000,16'h0000,1'b0}, // R5 bits cleared
    {1'b0,1'b0,1'b0,16'hAAAA,16'h0000,1'b0}, // R7 short load
    {1'b0,1'b1,1'b0,16'h0003,16'h0000,1'b0}, // R7 early instruction
    {1'b1,1'b1,1'b1,16'h0000,16'h0002,1'b0}, // R7 error set
    {1'b0,1'b1,1'b0,16'h0007,16'h0000,1'b0}, // R10 illegal code
    {1'b1,1'b1,1'b1,16'h0000,16'h0006,1'b0}, // R10 bit 2 seen
    {1'b1,1'b1,1'b1,16'h0000,16'h0002,1'b0}, // R10 cleared by read
    {1'b0,1'b1,1'b0,16'h0001,16'h0000,1'b0}, // R5 clean load
    {1'b0,1'b0,1'b0,16'h0101,16'h0000,1'b0}, // R5
    {1'b0,1'b0,1'b0,16'h0202,16'h0000,1'b0}, // R5
    {1'b0,1'b0,1'b0,16'h0303,16'h0000,1'b1}, // R6
    {1'b0,1'b1,1'b0,16'h0002,16'h0000,1'b0}, // R8 start, R4 instruction clears irq
    {1'b1,1'b1,1'b1,16'h0000,16'h0009,1'b0}, // R8 running bit
    {1'b1,1'b0,1'b1,16'h0000,16'h5A5A,1'b0}  // R9 conversion word
  };

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R3 irq low in reset", irq, 1'b0);
    chk("R2 bus_oe low in reset", bus_oe, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 irq after reset", irq, 1'b1);
    for (int i = 0; i < NV; i++) begin
      bus_op(VEC[i][35], VEC[i][34], VEC[i][32:17]);
      if (VEC[i][33]) begin
        chk($sformatf("R1 R2 read step %0d", i), rd_val, VEC[i][16:1]);
        chk($sformatf("R2 oe step %0d", i), oe_seen, 1'b1);
      end
      chk($sformatf("R4 R6 irq step %0d", i), irq, VEC[i][0]);
    end
    chk("R5 word 0", store[0], 16'h0101);
    chk("R5 word 1", store[1], 16'h0202);
    chk("R5 word 2", store[2], 16'h0303);
    chk("R2 R5 write count", wcount, 32'd7);
    par_mode_n = 1'b1;
    bus_op(1'b0, 1'b1, 16'h0001);
    bus_op(1'b1, 1'b1, 16'h0000);
    chk("R11 oe held low", oe_seen, 1'b0);
    par_mode_n = 1'b0;
    bus_op(1'b1, 1'b1, 16'h0000);
    chk("R11 load ignored", rd_val, 16'h0009);
    chk("R11 no storage write", wcount, 32'd7);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule